// File: doc/BRIEF.md
# Flow-through synchronous SRAM with zero-turnaround read/write

This block is a small synchronous static memory whose read data flows straight from the array to the data bus in the same cycle the read is accepted. Address and command are registered on the rising clock edge. Write data follows its address by one cycle. Because a read's data and a write's data both occupy the cycle after their command, reads and writes can alternate on every clock with no idle bus cycle between them. A write is held in a small pending buffer until the next write arrives. A read that hits the pending address is served by merging the buffered lanes over the array word, lane by lane.

The word is 36 bits, split into four 9-bit lanes (8 data bits plus a parity bit). Lane `l` occupies bits `[9l+8:9l]`. A two-bit burst counter walks the low address bits in either linear or interleaved order. A clock enable freezes the whole block. Three chip selects gate the start of every new operation. An asynchronous output enable gates the drive. The bidirectional data bus is modelled as a separate input, output and drive-enable.

Top module: `nbl_sram_ft`

## Requirements
- R1: A synchronous reset clears the array to zero, empties the pending write and leaves the block idle, so `dq_oe` and `dq_out` are 0 and a later read of an unwritten word returns 0.
- R2: When `adv`=0 and all selects are 1 with `wr_en`=0, the word at `addr` appears on `dq_out` with `dq_oe`=1 during the cycle right after that edge, provided `out_en`=1.
- R3: Write data on `dq_in` is sampled at the enabled edge after the write's address edge. Only lanes whose `lane_wr` bit is 1 change. Bit `l` selects bits `[9l+8:9l]`.
- R4: A read accepted at the edge that captures a write's data, or any later read of that address, returns the new data. Writes and reads may alternate on every cycle.
- R5: A load cycle with any of `sel_a`, `sel_b`, `sel_c` low is a deselect: nothing is written and nothing is driven.
- R6: During the data cycle of a write, `dq_oe` is 0 whatever `out_en` is.
- R7: `out_en`=0 forces `dq_oe`=0 without a clock edge. Whenever `dq_oe` is 0, `dq_out` is 0.
- R8: At an edge where `clk_en`=0, no state changes: outputs, pending write and array hold, and `dq_in` is not sampled.
- R9: `adv`=1 continues the current operation type and keeps the upper address bits. On such cycles `wr_en` and the selects are ignored, while `lane_wr` is sampled afresh for each write beat.
- R10: With `burst_ilv`=0 at the load, beat k (k=0..3) uses low address bits (start + k) mod 4.
- R11: With `burst_ilv`=1 at the load, beat k uses low bits start XOR k. The order is fixed at the load.
- R12: `adv`=1 after a deselect continues the deselect, so nothing is driven or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | 1 = edge takes effect, 0 = cycle is extended |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| wr_en | input | 1 | 1 = write, 0 = read (load cycles only) |
| lane_wr | input | 4 | Per-lane write select |
| adv | input | 1 | 0 = load new address and command, 1 = advance burst |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| out_en | input | 1 | Asynchronous output drive gate |
| addr | input | ADDR_W | Word address |
| dq_in | input | 36 | Write data, one cycle after its address |
| dq_out | output | 36 | Read data, flow-through |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a read that has to merge a partially written, still-buffered word. This happens only when a write with a sparse lane mask is followed directly by a read of the same address, before any other write pushes the buffer into the array. The stimulus sets this up with a full write, then a two-lane write and an immediate read of that word. A further write then forces the commit, and the word is read again. Suspended cycles are placed across both a read and a write data phase, and burst walks in both orders start from non-zero low address bits so the wrap is exercised.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
    localparam int unsigned LANES   = 4;
    localparam int unsigned LANE_W  = 9;
    localparam int unsigned DATA_W  = LANES * LANE_W;
    localparam int unsigned BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [LANES-1:0] lanes;
    } op_t;

    typedef struct packed {
        logic              valid;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] data;
    } pend_t;

    function automatic logic [BURST_W-1:0] beat_low(
        input order_e ord,
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat
    );
        if (ord == ORD_INTERLEAVE) return start ^ beat;
        return start + beat;
    endfunction
endpackage

// File: rtl/nbl_burst_ctrl.sv
module nbl_burst_ctrl
    import nbl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              sel_all,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_wr,
    input  logic              ord_in,
    input  logic [ADDR_W-1:0] addr_in,
    output op_t               op,
    output logic [ADDR_W-1:0] op_addr
);
    localparam int unsigned HI_W = ADDR_W - BURST_W;

    op_t                op_q;
    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] beat_q;
    order_e             ord_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= '0;
            hi_q    <= '0;
            start_q <= '0;
            beat_q  <= '0;
            ord_q   <= ORD_LINEAR;
        end else if (step_en) begin
            if (!adv) begin
                beat_q <= '0;
                if (sel_all) begin
                    op_q    <= '{valid: 1'b1, write: wr_en, lanes: (wr_en ? lane_wr : '0)};
                    hi_q    <= addr_in[ADDR_W-1:BURST_W];
                    start_q <= addr_in[BURST_W-1:0];
                    ord_q   <= order_e'(ord_in);
                end else begin
                    op_q <= '0;
                end
            end else begin
                beat_q <= beat_q + 2'd1;
                if (op_q.write) op_q.lanes <= lane_wr;
            end
        end
    end

    assign op      = op_q;
    assign op_addr = {hi_q, beat_low(ord_q, start_q, beat_q)};

    // R9: a continuation keeps the upper address and the operation type
    p_upper_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (step_en && adv) |=> ($stable(op_addr[ADDR_W-1:BURST_W]) && $stable(op.write) && $stable(op.valid)));

    // R10: linear bursts step the low bits by one, wrapping at four
    p_linear_step_r10: assert property (@(posedge clk) disable iff (rst)
        (step_en && adv && op_q.valid && ord_q == ORD_LINEAR)
        |=> (op_addr[BURST_W-1:0] == $past(op_addr[BURST_W-1:0]) + 2'd1));
endmodule

// File: rtl/nbl_store.sv
module nbl_store
    import nbl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_en,
    input  op_t               op,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    pend_t             pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_hit;
    logic [DATA_W-1:0] arr_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            pend_q      <= '0;
            pend_addr_q <= '0;
        end else if (commit_en && op.valid && op.write) begin
            if (pend_q.valid) begin
                for (int l = 0; l < LANES; l++) begin
                    if (pend_q.lanes[l])
                        mem_q[pend_addr_q][l*LANE_W +: LANE_W] <= pend_q.data[l*LANE_W +: LANE_W];
                end
            end
            pend_q      <= '{valid: 1'b1, lanes: op.lanes, data: wdata};
            pend_addr_q <= op_addr;
        end
    end

    assign arr_word = mem_q[op_addr];
    assign pend_hit = pend_q.valid && (pend_addr_q == op_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_merge
        assign rdata[l*LANE_W +: LANE_W] = (pend_hit && pend_q.lanes[l])
                                           ? pend_q.data[l*LANE_W +: LANE_W]
                                           : arr_word[l*LANE_W +: LANE_W];
    end

    // R3: write data is taken at the edge after its address, with its address
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (commit_en && op.valid && op.write)
        |=> (pend_q.valid && pend_q.data == $past(wdata) && pend_addr_q == $past(op_addr)));
endmodule

// File: rtl/nbl_sram_ft.sv
module nbl_sram_ft
    import nbl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_c,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_wr,
    input  logic              adv,
    input  logic              burst_ilv,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              sel_all;
    op_t               op;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] rdata;

    assign sel_all = sel_a & sel_b & sel_c;

    nbl_burst_ctrl #(.ADDR_W(ADDR_W)) u_burst (
        .clk     (clk),
        .rst     (rst),
        .step_en (clk_en),
        .sel_all (sel_all),
        .adv     (adv),
        .wr_en   (wr_en),
        .lane_wr (lane_wr),
        .ord_in  (burst_ilv),
        .addr_in (addr),
        .op      (op),
        .op_addr (op_addr)
    );

    nbl_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .commit_en (clk_en),
        .op        (op),
        .op_addr   (op_addr),
        .wdata     (dq_in),
        .rdata     (rdata)
    );

    assign dq_oe  = out_en & op.valid & ~op.write;
    assign dq_out = dq_oe ? rdata : '0;

    // R6: no drive during the data cycle of a freshly loaded write
    p_write_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv && sel_all && wr_en) |=> !dq_oe);

    // R5: an unselected load leaves the bus undriven
    p_deselect_r5: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv && !sel_all) |=> !dq_oe);

    // R12: advancing after a deselect stays deselected
    p_desel_burst_r12: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv && !sel_all) ##1 (clk_en && adv) |=> !dq_oe);

    // R8: a suspended edge leaves the outputs unchanged
    p_suspend_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clk_en) |=> ($stable(out_en) |-> ($stable(dq_oe) && $stable(dq_out))));

    // R7: no data leaks onto the output while not driving
    always_comb begin
        if (!rst && !dq_oe) begin
            p_quiet_zero_r7: assert (dq_out == '0);
        end
    end
endmodule

// File: tb/tb_nbl_sram_ft.sv
module tb_nbl_sram_ft;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  lane_wr = 4'h0;
    logic        adv = 1'b0;
    logic        burst_ilv = 1'b0;
    logic        out_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [35:0] dq_in = '0;
    logic [35:0] dq_out;
    logic        dq_oe;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    nbl_sram_ft #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .clk_en(clk_en),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .wr_en(wr_en), .lane_wr(lane_wr), .adv(adv), .burst_ilv(burst_ilv),
        .out_en(out_en), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        bit          en;
        bit [2:0]    sel;
        bit          adv;
        bit          we;
        bit [3:0]    lanes;
        bit          ilv;
        bit [AW-1:0] a;
        bit [35:0]   wd;
        bit          oe;
        string       req;
    } cmd_t;

    typedef struct {
        bit          drive;
        logic [35:0] data;
        string       req;
    } exp_t;

    exp_t sbq[$];

    // reference memory and the bench's own view of the operation in its data cycle
    logic [35:0] ref_mem [1 << AW];
    bit          m_valid, m_write, m_ilv;
    bit [AW-3:0] m_hi;
    bit [1:0]    m_start, m_beat;
    bit [3:0]    m_lanes;
    bit [35:0]   held_wd;
    bit          held_oe;
    string       held_req = "R1";

    function automatic cmd_t c_load(bit we, bit [AW-1:0] a, bit [3:0] lanes, bit [35:0] wd,
                                    bit oe, bit ilv, string req);
        cmd_t c;
        c.en = 1; c.sel = 3'b111; c.adv = 0; c.we = we; c.lanes = lanes; c.ilv = ilv;
        c.a = a; c.wd = wd; c.oe = oe; c.req = req;
        return c;
    endfunction

    function automatic cmd_t c_adv(bit [3:0] lanes, bit [35:0] wd, string req);
        cmd_t c;
        c.en = 1; c.sel = 3'b000; c.adv = 1; c.we = 0; c.lanes = lanes; c.ilv = 0;
        c.a = 8'hFF; c.wd = wd; c.oe = 1; c.req = req;
        return c;
    endfunction

    function automatic cmd_t c_hold(string req);
        cmd_t c;
        c.en = 0; c.sel = 3'b111; c.adv = 0; c.we = 1; c.lanes = 4'hF; c.ilv = 0;
        c.a = 8'h00; c.wd = 36'h0; c.oe = 1; c.req = req;
        return c;
    endfunction

    function automatic cmd_t c_desel(bit [2:0] sel, bit we, bit [AW-1:0] a, bit [35:0] wd, string req);
        cmd_t c;
        c.en = 1; c.sel = sel; c.adv = 0; c.we = we; c.lanes = 4'hF; c.ilv = 0;
        c.a = a; c.wd = wd; c.oe = 1; c.req = req;
        return c;
    endfunction

    task automatic step(input cmd_t c);
        exp_t e;
        bit [AW-1:0] ea;
        @(posedge clk);
        #1;
        dq_in  = held_wd;
        out_en = held_oe;
        ea = {m_hi, (m_ilv ? (m_start ^ m_beat) : (m_start + m_beat))};
        e.drive = m_valid && !m_write && held_oe;
        e.data  = e.drive ? ref_mem[ea] : 36'h0;
        e.req   = held_req;
        sbq.push_back(e);
        clk_en    = c.en;
        sel_a     = c.sel[0]; sel_b = c.sel[1]; sel_c = c.sel[2];
        adv       = c.adv;
        wr_en     = c.we;
        lane_wr   = c.lanes;
        burst_ilv = c.ilv;
        addr      = c.a;
        if (c.en) begin
            if (m_valid && m_write) begin
                for (int l = 0; l < 4; l++)
                    if (m_lanes[l]) ref_mem[ea][l*9 +: 9] = held_wd[l*9 +: 9];
            end
            if (!c.adv) begin
                m_beat = 0;
                if (&c.sel) begin
                    m_valid = 1; m_write = c.we; m_lanes = c.we ? c.lanes : 4'h0;
                    m_hi = c.a[AW-1:2]; m_start = c.a[1:0]; m_ilv = c.ilv;
                end else begin
                    m_valid = 0; m_write = 0; m_lanes = 0;
                end
            end else begin
                m_beat = m_beat + 2'd1;
                if (m_write) m_lanes = c.lanes;
            end
            held_wd  = c.wd;
            held_oe  = c.oe;
            held_req = c.req;
        end
    endtask

    // monitor: compares the outputs late in each cycle against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (dq_oe !== e.drive || dq_out !== e.data) begin
                    failures++;
                    $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
                             e.req, dq_oe, dq_out, e.drive, e.data);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        m_valid = 0; m_write = 0; m_ilv = 0; m_hi = 0; m_start = 0; m_beat = 0;
        m_lanes = 0; held_wd = 0; held_oe = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #3;
        // R1: idle after reset
        checks++;
        if (dq_oe !== 1'b0 || dq_out !== 36'h0) begin
            failures++;
            $display("FAIL R1: dq_oe=%0b dq_out=%h expected 0 and 0", dq_oe, dq_out);
        end

        // R1: unwritten word reads as zero
        step(c_load(0, 8'h55, 4'h0, 36'h0, 1, 0, "R1"));
        // R6 write data cycle undriven; R4 read of the word just written; alternating
        step(c_load(1, 8'h10, 4'hF, 36'hA_1111_1111, 1, 0, "R6"));
        step(c_load(0, 8'h10, 4'h0, 36'h0, 1, 0, "R4"));
        step(c_load(1, 8'h11, 4'hF, 36'hB_2222_2222, 1, 0, "R6"));
        step(c_load(0, 8'h10, 4'h0, 36'h0, 1, 0, "R2"));
        step(c_load(0, 8'h11, 4'h0, 36'h0, 1, 0, "R4"));
        // R3: partial lanes 0 and 2, merged while buffered, then after commit
        step(c_load(1, 8'h10, 4'b0101, 36'hC_3333_3333, 1, 0, "R3"));
        step(c_load(0, 8'h10, 4'h0, 36'h0, 1, 0, "R3"));
        step(c_load(1, 8'h20, 4'hF, 36'hD_4444_4444, 1, 0, "R3"));
        step(c_load(0, 8'h10, 4'h0, 36'h0, 1, 0, "R3"));
        // R7: read with the output gate low
        step(c_load(0, 8'h11, 4'h0, 36'h0, 0, 0, "R7"));
        // R5: write with one select low is dropped
        step(c_desel(3'b101, 1, 8'h11, 36'hE_5555_5555, "R5"));
        step(c_load(0, 8'h11, 4'h0, 36'h0, 1, 0, "R5"));
        // R8: suspend across a read and across a write data cycle
        step(c_load(0, 8'h20, 4'h0, 36'h0, 1, 0, "R8"));
        step(c_hold("R8"));
        step(c_hold("R8"));
        step(c_load(1, 8'h30, 4'hF, 36'hF_6666_6666, 1, 0, "R8"));
        step(c_hold("R8"));
        step(c_hold("R8"));
        step(c_load(0, 8'h30, 4'h0, 36'h0, 1, 0, "R8"));
        // R9/R10: linear write burst from low bits 2, beats ignore wr_en and selects
        step(c_load(1, 8'h42, 4'hF, 36'h0_1000_0000, 1, 0, "R9"));
        step(c_adv(4'hF, 36'h0_1000_0001, "R9"));
        step(c_adv(4'hF, 36'h0_1000_0002, "R9"));
        step(c_adv(4'b0011, 36'h0_1000_0003, "R9"));
        step(c_load(0, 8'h42, 4'h0, 36'h0, 1, 0, "R10"));
        step(c_adv(4'h0, 36'h0, "R10"));
        step(c_adv(4'h0, 36'h0, "R10"));
        step(c_adv(4'h0, 36'h0, "R10"));
        step(c_load(0, 8'h40, 4'h0, 36'h0, 1, 0, "R10"));
        // R11: interleaved write burst from low bits 1, then interleaved read from 2
        step(c_load(1, 8'h61, 4'hF, 36'h2_0000_0000, 1, 1, "R11"));
        step(c_adv(4'hF, 36'h2_0000_0001, "R11"));
        step(c_adv(4'hF, 36'h2_0000_0002, "R11"));
        step(c_adv(4'hF, 36'h2_0000_0003, "R11"));
        step(c_load(0, 8'h63, 4'h0, 36'h0, 1, 0, "R11"));
        step(c_load(0, 8'h62, 4'h0, 36'h0, 1, 1, "R11"));
        step(c_adv(4'h0, 36'h0, "R11"));
        step(c_adv(4'h0, 36'h0, "R11"));
        step(c_adv(4'h0, 36'h0, "R11"));
        // R12: advancing after a deselect stays quiet
        step(c_desel(3'b011, 0, 8'h10, 36'h0, "R12"));
        step(c_adv(4'hF, 36'h3_0000_0000, "R12"));
        step(c_adv(4'hF, 36'h3_0000_0001, "R12"));
        step(c_load(0, 8'h10, 4'h0, 36'h0, 1, 0, "R12"));
        step(c_desel(3'b000, 0, 8'h00, 36'h0, "R5"));
        step(c_desel(3'b000, 0, 8'h00, 36'h0, "R5"));
        @(posedge clk);
        #6;
        while (sbq.size() > 0) begin
            @(posedge clk);
            #6;
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule